// File: doc/BRIEF.md
# Byte Execute Datapath with Pointer-Based Indirect Addressing

This block is the 8-bit execute stage of a small accumulator-style controller. It holds a working register (W) and a 32-location file space. Most byte operations take their first operand from a file location and their second from W. A destination bit then sends the result either back to that file location or into W. The file space contains ordinary data registers and two special locations. One is the status byte, which carries the arithmetic flags. The other is a pointer register. Location 0 has no storage of its own: every access to it is redirected to the location whose address the pointer holds.

The surrounding controller decodes each instruction and presents an operation code, a file address, a literal and a destination bit. It then pulses a write strobe for one cycle. Reads of the addressed location and the skip verdict are combinational, and results land on the rising edge. Every strobe is accepted: the block applies no back-pressure and has no ready signal, so the controller may issue one operation per cycle without waiting.

Top module: `byte_datapath`

## Requirements
- R1: ADD, AND, OR and XOR take the addressed file location as the first operand and W as the second. The result is the 8-bit sum, AND, OR or XOR of the two operands.
- R2: For MOV, ADD, AND, OR, XOR, INC, DEC and CLR, a destination bit of 1 writes the result to the file location and 0 writes it to W. The other target keeps its value. MOV copies the location, INC adds one, DEC subtracts one, and CLR yields zero.
- R3: LDL loads the literal into W. STW copies W into the addressed file location. Neither operation changes any flag.
- R4: File address 0 is indirect. A read or write of address 0 acts on the location given by the low 5 bits of the pointer register at address 4. The pointer can be loaded like any other location.
- R5: While the pointer's low 5 bits are 0, reading address 0 returns 0 and writing address 0 changes nothing.
- R6: The status byte sits at address 3. Carry is bit 0, digit carry is bit 1, zero is bit 2, power-down is bit 3 and timeout is bit 4. Bits 3 and 4 always read 1 and ignore writes. Bits 0 to 2 and 5 to 7 take written values.
- R7: MOV, ADD, AND, OR, XOR, INC, DEC and CLR set the zero flag when their 8-bit result is 0 and clear it otherwise. No other operation changes the zero flag.
- R8: Only ADD changes carry and digit carry. Carry becomes the carry out of bit 7, and digit carry becomes the carry out of bit 3.
- R9: BSET sets and BCLR clears one bit of the addressed file location. The bit index is the literal's bits [2:0].
- R10: SKS raises skip_o when the indexed bit is 1, and SKC raises it when the bit is 0. Neither writes anything. skip_o is 0 for every other operation.
- R11: State changes only on a rising clock edge with wr_i high. fdata_o, which shows the resolved addressed location, and skip_o follow the inputs combinationally. No strobe is ever refused.
- R12: When an operation writes its result to the status byte, the written value wins over that operation's own flag update.
- R13: Reset (rst_n low) clears W, the pointer, all data registers and status bits 0 to 2 and 5 to 7.
- R14: Operation encodings are NOP=0, LDL=1, STW=2, MOV=3, ADD=4, AND=5, OR=6, XOR=7, INC=8, DEC=9, CLR=10, BSET=11, BCLR=12, SKS=13 and SKC=14. Code 15 acts as NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_i | input | 4 | Operation code |
| faddr_i | input | 5 | File address (0 = indirect) |
| lit_i | input | 8 | Literal; bits [2:0] are also the bit index |
| dest_i | input | 1 | 1 = result to file, 0 = result to W |
| wr_i | input | 1 | Execute strobe |
| w_o | output | 8 | Working register |
| fdata_o | output | 8 | Resolved content of the addressed location |
| skip_o | output | 1 | Skip condition of a bit test |
| carry_o | output | 1 | Carry flag |
| dcarry_o | output | 1 | Digit carry flag |
| zero_o | output | 1 | Zero flag |

## Verification
Two updates can land on the status byte in the same cycle. An arithmetic or logic operation writes its result there, either directly at address 3 or through the pointer, and the same operation also updates its own flags. The bench provokes this with directed CLR and ADD operations aimed at the status byte, and it also reaches it at random through the indirect address. The result is judged against a model in which the written byte wins, with the read-only bits still at 1. A second pairing occurs when the pointer targets itself or the status byte while an indirect write is executing. This pairing is covered by random pointer values and by a full sweep of the file space that compares every location against the model.

// File: rtl/bdp_pkg.sv
package bdp_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 5;

  localparam int A_IND  = 0;
  localparam int A_STAT = 3;
  localparam int A_PTR  = 4;

  localparam int SB_C  = 0;
  localparam int SB_DC = 1;
  localparam int SB_Z  = 2;
  localparam int SB_PD = 3;
  localparam int SB_TO = 4;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_LDL  = 4'd1,
    OP_STW  = 4'd2,
    OP_MOV  = 4'd3,
    OP_ADD  = 4'd4,
    OP_AND  = 4'd5,
    OP_OR   = 4'd6,
    OP_XOR  = 4'd7,
    OP_INC  = 4'd8,
    OP_DEC  = 4'd9,
    OP_CLR  = 4'd10,
    OP_BSET = 4'd11,
    OP_BCLR = 4'd12,
    OP_SKS  = 4'd13,
    OP_SKC  = 4'd14
  } op_e;
endpackage

// File: rtl/bdp_resolve.sv
module bdp_resolve
  import bdp_pkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] ptr_i,
  output logic [AW-1:0] eff_o,
  output logic          null_o
);
  localparam logic [AW-1:0] IND = AW'(A_IND);

  always_comb begin
    eff_o  = (addr_i == IND) ? ptr_i : addr_i;
    null_o = (eff_o == IND);
  end
endmodule

// File: rtl/bdp_alu.sv
module bdp_alu
  import bdp_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  op_e           op_i,
  input  logic [DW-1:0] fval_i,
  input  logic [DW-1:0] wval_i,
  input  logic [DW-1:0] lit_i,
  input  logic          dest_i,
  output logic [DW-1:0] res_o,
  output logic          to_file_o,
  output logic          to_w_o,
  output logic          z_upd_o,
  output logic          cdc_upd_o,
  output logic          z_o,
  output logic          c_o,
  output logic          dc_o,
  output logic          skip_o
);
  localparam int HW = DW / 2;
  localparam int BW = $clog2(DW);
  localparam logic [DW-1:0] ONE = DW'(1);

  logic [DW:0]   sum;
  logic [HW:0]   lsum;
  logic [BW-1:0] bidx;
  logic [DW-1:0] bmask;

  always_comb begin
    sum   = {1'b0, fval_i} + {1'b0, wval_i};
    lsum  = {1'b0, fval_i[HW-1:0]} + {1'b0, wval_i[HW-1:0]};
    bidx  = lit_i[BW-1:0];
    bmask = ONE << bidx;
    res_o     = '0;
    to_file_o = 1'b0;
    to_w_o    = 1'b0;
    z_upd_o   = 1'b0;
    cdc_upd_o = 1'b0;
    skip_o    = 1'b0;
    unique case (op_i)
      OP_LDL:  begin res_o = lit_i;  to_w_o = 1'b1; end
      OP_STW:  begin res_o = wval_i; to_file_o = 1'b1; end
      OP_MOV:  begin res_o = fval_i;           z_upd_o = 1'b1; end
      OP_ADD:  begin res_o = sum[DW-1:0];      z_upd_o = 1'b1; cdc_upd_o = 1'b1; end
      OP_AND:  begin res_o = fval_i & wval_i;  z_upd_o = 1'b1; end
      OP_OR:   begin res_o = fval_i | wval_i;  z_upd_o = 1'b1; end
      OP_XOR:  begin res_o = fval_i ^ wval_i;  z_upd_o = 1'b1; end
      OP_INC:  begin res_o = fval_i + ONE;     z_upd_o = 1'b1; end
      OP_DEC:  begin res_o = fval_i - ONE;     z_upd_o = 1'b1; end
      OP_CLR:  begin res_o = '0;               z_upd_o = 1'b1; end
      OP_BSET: begin res_o = fval_i | bmask;  to_file_o = 1'b1; end
      OP_BCLR: begin res_o = fval_i & ~bmask; to_file_o = 1'b1; end
      OP_SKS:  skip_o = fval_i[bidx];
      OP_SKC:  skip_o = ~fval_i[bidx];
      default: ;
    endcase
    if (z_upd_o) begin
      to_file_o = dest_i;
      to_w_o    = ~dest_i;
    end
    z_o  = (res_o == '0);
    c_o  = sum[DW];
    dc_o = lsum[HW];
  end
endmodule

// File: rtl/bdp_regbank.sv
module bdp_regbank
  import bdp_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          z_we_i,
  input  logic          cdc_we_i,
  input  logic          z_i,
  input  logic          c_i,
  input  logic          dc_i,
  output logic [DW-1:0] rd_data_o,
  output logic [AW-1:0] ptr_o,
  output logic [DW-1:0] stat_o
);
  localparam int NREG = 2 ** AW;
  localparam logic [AW-1:0] IND  = AW'(A_IND);
  localparam logic [AW-1:0] STAT = AW'(A_STAT);
  localparam logic [AW-1:0] PTR  = AW'(A_PTR);
  localparam logic [DW-1:0] RO_MASK = (DW'(1) << SB_PD) | (DW'(1) << SB_TO);

  logic [DW-1:0] gp_q [NREG];
  logic [DW-1:0] ptr_q;
  logic [DW-1:0] stat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) gp_q[i] <= '0;
    end else if (wr_en_i && wr_addr_i != IND && wr_addr_i != STAT && wr_addr_i != PTR) begin
      gp_q[wr_addr_i] <= wr_data_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else if (wr_en_i && wr_addr_i == PTR) ptr_q <= wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= RO_MASK;
    end else if (wr_en_i && wr_addr_i == STAT) begin
      stat_q <= wr_data_i | RO_MASK;
    end else begin
      if (z_we_i) stat_q[SB_Z] <= z_i;
      if (cdc_we_i) begin
        stat_q[SB_C]  <= c_i;
        stat_q[SB_DC] <= dc_i;
      end
    end
  end

  always_comb begin
    if (rd_addr_i == IND)       rd_data_o = '0;
    else if (rd_addr_i == STAT) rd_data_o = stat_q;
    else if (rd_addr_i == PTR)  rd_data_o = ptr_q;
    else                        rd_data_o = gp_q[rd_addr_i];
  end

  assign ptr_o  = ptr_q[AW-1:0];
  assign stat_o = stat_q;

  AST_RO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    stat_q[SB_PD] && stat_q[SB_TO]); // R6
  AST_STAT_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_addr_i == STAT) |=> stat_q == ($past(wr_data_i) | RO_MASK)); // R12
endmodule

// File: rtl/byte_datapath.sv
module byte_datapath
  import bdp_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    op_i,
  input  logic [AW-1:0] faddr_i,
  input  logic [DW-1:0] lit_i,
  input  logic          dest_i,
  input  logic          wr_i,
  output logic [DW-1:0] w_o,
  output logic [DW-1:0] fdata_o,
  output logic          skip_o,
  output logic          carry_o,
  output logic          dcarry_o,
  output logic          zero_o
);
  localparam logic [AW-1:0] STAT = AW'(A_STAT);

  op_e           op;
  logic [DW-1:0] w_q;
  logic [AW-1:0] ptr;
  logic [AW-1:0] eff;
  logic          is_null;
  logic [DW-1:0] fval;
  logic [DW-1:0] stat;
  logic [DW-1:0] res;
  logic          to_file, to_w, z_upd, cdc_upd, z, c, dc, skip;
  logic          file_we, stat_hit;

  assign op = op_e'(op_i);

  bdp_resolve #(.AW(AW)) u_resolve (
    .addr_i (faddr_i),
    .ptr_i  (ptr),
    .eff_o  (eff),
    .null_o (is_null)
  );

  bdp_alu #(.DW(DW)) u_alu (
    .op_i      (op),
    .fval_i    (fval),
    .wval_i    (w_q),
    .lit_i     (lit_i),
    .dest_i    (dest_i),
    .res_o     (res),
    .to_file_o (to_file),
    .to_w_o    (to_w),
    .z_upd_o   (z_upd),
    .cdc_upd_o (cdc_upd),
    .z_o       (z),
    .c_o       (c),
    .dc_o      (dc),
    .skip_o    (skip)
  );

  assign file_we  = wr_i && to_file && !is_null;
  assign stat_hit = file_we && (eff == STAT);

  bdp_regbank #(.DW(DW), .AW(AW)) u_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_addr_i (eff),
    .wr_en_i   (file_we),
    .wr_addr_i (eff),
    .wr_data_i (res),
    .z_we_i    (wr_i && z_upd && !stat_hit),
    .cdc_we_i  (wr_i && cdc_upd && !stat_hit),
    .z_i       (z),
    .c_i       (c),
    .dc_i      (dc),
    .rd_data_o (fval),
    .ptr_o     (ptr),
    .stat_o    (stat)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) w_q <= '0;
    else if (wr_i && to_w) w_q <= res;
  end

  assign w_o      = w_q;
  assign fdata_o  = fval;
  assign skip_o   = skip;
  assign carry_o  = stat[SB_C];
  assign dcarry_o = stat[SB_DC];
  assign zero_o   = stat[SB_Z];

  AST_LIT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && op_i == OP_LDL) |=> w_o == $past(lit_i)); // R3
  AST_NULL_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (faddr_i == '0 && ptr == '0) |-> fdata_o == '0); // R5
  AST_ADD_TO_W: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && op_i == OP_ADD && !dest_i) |=> w_o == DW'($past(fdata_o) + $past(w_o))); // R1
  AST_DEST_FILE_KEEPS_W: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && dest_i && op_i >= OP_MOV && op_i <= OP_CLR) |=> $stable(w_o)); // R2
  AST_TEST_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && (op_i == OP_SKS || op_i == OP_SKC)) |=> $stable(w_o) && $stable(stat)); // R10
endmodule

// File: tb/byte_datapath_test.sv
`timescale 1ns/1ps
module byte_datapath_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] op;
  logic [4:0] faddr;
  logic [7:0] lit;
  logic       dest;
  logic       wr;
  logic [7:0] w_o, fdata_o;
  logic       skip_o, carry_o, dcarry_o, zero_o;

  int checks = 0;
  int fails  = 0;

  logic [7:0] m [32];
  logic [7:0] mw, mptr, mstat;

  always #5 clk = ~clk;

  byte_datapath uut (
    .clk(clk), .rst_n(rst_n), .op_i(op), .faddr_i(faddr), .lit_i(lit),
    .dest_i(dest), .wr_i(wr), .w_o(w_o), .fdata_o(fdata_o), .skip_o(skip_o),
    .carry_o(carry_o), .dcarry_o(dcarry_o), .zero_o(zero_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [4:0] eff(logic [4:0] a);
    return (a == 5'd0) ? mptr[4:0] : a;
  endfunction

  function automatic logic [7:0] mread(logic [4:0] e);
    if (e == 5'd0) return 8'h00;
    if (e == 5'd3) return mstat;
    if (e == 5'd4) return mptr;
    return m[e];
  endfunction

  task automatic mwrite(logic [4:0] e, logic [7:0] v);
    if (e == 5'd0) return;
    if (e == 5'd3) mstat = v | 8'h18;
    else if (e == 5'd4) mptr = v;
    else m[e] = v;
  endtask

  function automatic string tag(logic [3:0] o);
    case (o)
      4'd1, 4'd2: return "R3";
      4'd4: return "R8";
      4'd5, 4'd6, 4'd7: return "R1";
      4'd3, 4'd8, 4'd9, 4'd10: return "R2";
      4'd11, 4'd12: return "R9";
      4'd13, 4'd14: return "R10";
      default: return "R14";
    endcase
  endfunction

  task automatic exec(logic [3:0] o, logic [4:0] a, logic [7:0] l, logic d);
    logic [4:0] e;
    logic [7:0] f, r;
    logic [8:0] s;
    logic [4:0] ls;
    logic tf, tw, zu, cu, sk;
    e = eff(a); f = mread(e);
    s = {1'b0, f} + {1'b0, mw};
    ls = {1'b0, f[3:0]} + {1'b0, mw[3:0]};
    r = 8'h00; tf = 0; tw = 0; zu = 0; cu = 0; sk = 0;
    case (o)
      4'd1: begin r = l; tw = 1; end
      4'd2: begin r = mw; tf = 1; end
      4'd3: begin r = f; zu = 1; end
      4'd4: begin r = s[7:0]; zu = 1; cu = 1; end
      4'd5: begin r = f & mw; zu = 1; end
      4'd6: begin r = f | mw; zu = 1; end
      4'd7: begin r = f ^ mw; zu = 1; end
      4'd8: begin r = f + 8'd1; zu = 1; end
      4'd9: begin r = f - 8'd1; zu = 1; end
      4'd10: begin r = 8'h00; zu = 1; end
      4'd11: begin r = f | (8'd1 << l[2:0]); tf = 1; end
      4'd12: begin r = f & ~(8'd1 << l[2:0]); tf = 1; end
      4'd13: sk = f[l[2:0]];
      4'd14: sk = ~f[l[2:0]];
      default: ;
    endcase
    if (zu) begin tf = d; tw = ~d; end
    @(negedge clk);
    op = o; faddr = a; lit = l; dest = d; wr = 1'b1;
    #1;
    chk("R11 combinational read", fdata_o, f);
    chk({tag(o), " skip"}, skip_o, sk);
    @(posedge clk);
    #1;
    wr = 1'b0; op = 4'd0;
    if (tw) mw = r;
    if (tf) mwrite(e, r);
    if (!(tf && e == 5'd3)) begin
      if (zu) mstat[2] = (r == 8'h00);
      if (cu) begin mstat[0] = s[8]; mstat[1] = ls[4]; end
    end
    #1;
    chk({tag(o), " W"}, w_o, mw);
    chk({tag(o), " R7 zero"}, zero_o, mstat[2]);
    chk({tag(o), " R8 carry"}, {carry_o, dcarry_o}, {mstat[0], mstat[1]});
    chk({tag(o), " R4 readback"}, fdata_o, mread(eff(a)));
  endtask

  task automatic sweep(string req);
    for (int i = 0; i < 32; i++) begin
      faddr = 5'(i);
      #1;
      chk(req, fdata_o, mread(eff(5'(i))));
    end
  endtask

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4099));
    for (int i = 0; i < 32; i++) m[i] = 8'h00;
    mw = 8'h00; mptr = 8'h00; mstat = 8'h18;
    rst_n = 1'b0; op = 4'd0; faddr = 5'd0; lit = 8'h00; dest = 1'b0; wr = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;
    chk("R13 reset W", w_o, 8'h00);
    chk("R13 reset status", {zero_o, dcarry_o, carry_o}, 3'b000);
    sweep("R13 reset file space");

    // R8 digit carry: 0x0F + 0x01
    exec(4'd1, 5'd0, 8'h0F, 0);
    exec(4'd2, 5'd5, 8'h00, 0);
    exec(4'd1, 5'd0, 8'h01, 0);
    exec(4'd4, 5'd5, 8'h00, 0);
    chk("R8 digit carry", {carry_o, dcarry_o, zero_o}, 3'b010);
    // R8 carry and R7 zero: 0xFF + 0x01 into file
    exec(4'd1, 5'd0, 8'hFF, 0);
    exec(4'd2, 5'd6, 8'h00, 0);
    exec(4'd1, 5'd0, 8'h01, 0);
    exec(4'd4, 5'd6, 8'h00, 1);
    chk("R8 carry out", {carry_o, dcarry_o, zero_o}, 3'b111);
    // R4 indirect via pointer
    exec(4'd1, 5'd0, 8'h07, 0);
    exec(4'd2, 5'd4, 8'h00, 0);
    exec(4'd1, 5'd0, 8'hAA, 0);
    exec(4'd2, 5'd0, 8'h00, 0);
    faddr = 5'd7; #1;
    chk("R4 indirect write lands", fdata_o, 8'hAA);
    // R5 null pointer
    exec(4'd1, 5'd0, 8'h00, 0);
    exec(4'd2, 5'd4, 8'h00, 0);
    exec(4'd1, 5'd0, 8'h55, 0);
    exec(4'd2, 5'd0, 8'h00, 0);
    faddr = 5'd0; #1;
    chk("R5 null read", fdata_o, 8'h00);
    sweep("R5 null write dropped");
    // R6 status read-only bits
    exec(4'd1, 5'd0, 8'hFF, 0);
    exec(4'd2, 5'd3, 8'h00, 0);
    faddr = 5'd3; #1;
    chk("R6 status all ones", fdata_o, 8'hFF);
    exec(4'd1, 5'd0, 8'h00, 0);
    exec(4'd2, 5'd3, 8'h00, 0);
    faddr = 5'd3; #1;
    chk("R6 read-only bits stay", fdata_o, 8'h18);
    // R12 result to status wins over own flag update
    exec(4'd10, 5'd3, 8'h00, 1);
    chk("R12 CLR on status keeps zero clear", zero_o, 1'b0);
    exec(4'd1, 5'd0, 8'h01, 0);
    exec(4'd1, 5'd0, 8'hFF, 0);
    exec(4'd4, 5'd3, 8'h00, 1);
    chk("R12 ADD on status", {carry_o, dcarry_o, zero_o}, {mstat[0], mstat[1], mstat[2]});

    for (int n = 0; n < 3000; n++) begin
      logic [3:0] o;
      logic [4:0] a;
      o = 4'($urandom % 16);
      a = ($urandom % 4 == 0) ? 5'd0 : 5'($urandom % 32);
      exec(o, a, 8'($urandom), 1'($urandom));
      if (n % 500 == 0) sweep("R4 random sweep");
    end
    sweep("R14 final sweep");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule